// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block produces periodic update events from the core clock. A programmable prescaler divides the clock and sets the rate of a counter. The counter runs between zero and a programmable limit, either upward or downward. Each time it wraps, the block emits a one-cycle update pulse. If interrupts are enabled, the wrap also sets a sticky status flag that drives the interrupt output. The event period is (prescale+1)×(limit+1) clock cycles.

Software writes the prescale and limit values into holding registers. The running logic copies those values into its working registers only at an update event. This means a change never disturbs the period that is already in progress. Software can also force an update event. The forced event restarts both counting stages and loads the held values at once. This is the usual way to start the timer with a fresh configuration.

Top module: `tick_timer`

## Requirements
- R1: After reset, `count` is 0 and `upd_pulse`, `upd_flag` and `irq` are all 0. The reset prescale is 0 and the reset limit is all ones.
- R2: Register map (write port `wr_addr`): address 0 is control, with bit0 = run enable, bit1 = count down and bit2 = interrupt enable. Address 1 holds the prescale value. Address 2 holds the limit. Address 3 is a command register, with bit0 = force update and bit1 = clear flag, and each bit acts only in the cycle it is written. When counting up with prescale 0, `count` steps 0,1,…,limit on successive clocks. On the next step it returns to 0 and an update event occurs.
- R3: With prescale value P, `count` advances once every P+1 clock cycles. Update events then recur every (P+1)×(limit+1) cycles.
- R4: When counting down, `count` steps from the limit to 0. On the next step it reloads the limit and an update event occurs.
- R5: A prescale or limit write never changes the working values directly. The working values load from the held values only on an update event, so the current period completes with the old settings.
- R6: A force-update command, given while running, restarts the prescaler. It sets `count` to 0 when counting up, or to the newly loaded limit when counting down. It loads the held values and produces one update event. `upd_pulse` is high in the cycle after the command is captured.
- R7: `upd_pulse` goes high for one cycle in the cycle after each clock edge that performs an update event, and it is low at all other times.
- R8: When interrupt enable is 1, each update event sets `upd_flag`. The flag stays set until a clear-flag command is written. If a clear and an update event fall on the same edge, the flag ends up set.
- R9: `irq` is high exactly when `upd_flag` is set and interrupt enable is 1. With interrupt enable at 0, update events leave `upd_flag` unchanged.
- R10: While run enable is 0, `count` and the prescaler hold their values. No update event occurs, a force-update command is ignored, and `upd_pulse` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| upd_pulse | output | 1 | Registered one-cycle update event |
| upd_flag | output | 1 | Sticky update status flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is a clear-flag and a flag-setting update event. The bench triggers both together by writing one command word that has the force-update and clear-flag bits both set. The flag must then read set, which shows that setting wins. The second pair is a limit write and a natural wrap. The bench writes a new limit in the middle of a period. It then judges, cycle by cycle through the pulse scoreboard and the counter value, that the running period ends at the old limit and the following periods use the new one.

// File: rtl/tt_pkg.sv
`timescale 1ns/1ps
package tt_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_PSC   = 2'd1,
        A_LIMIT = 2'd2,
        A_CMD   = 2'd3
    } addr_e;

    // control word bit positions
    localparam int unsigned B_EN   = 0;
    localparam int unsigned B_DOWN = 1;
    localparam int unsigned B_IE   = 2;
    // command word bit positions
    localparam int unsigned B_FORCE = 0;
    localparam int unsigned B_CLR   = 1;

    typedef struct packed {
        logic ie;
        logic down;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/tt_regs.sv
`timescale 1ns/1ps
module tt_regs #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PSC_W  = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [tt_pkg::ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output tt_pkg::ctrl_t               ctrl,
    output logic [PSC_W-1:0]            psc_hold,
    output logic [CNT_W-1:0]            lim_hold,
    output logic                        force_req,
    output logic                        clr_req
);
    import tt_pkg::*;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [PSC_W-1:0]  psc;
        logic [CNT_W-1:0]  lim;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    s_d.ctrl.en   = wr_data[B_EN];
                    s_d.ctrl.down = wr_data[B_DOWN];
                    s_d.ctrl.ie   = wr_data[B_IE];
                end
                A_PSC:   s_d.psc = wr_data[PSC_W-1:0];
                A_LIMIT: s_d.lim = wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.lim  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl      = s_q.ctrl;
    assign psc_hold  = s_q.psc;
    assign lim_hold  = s_q.lim;
    assign force_req = wr_en && (wr_addr == A_CMD) && wr_data[B_FORCE];
    assign clr_req   = wr_en && (wr_addr == A_CMD) && wr_data[B_CLR];
endmodule

// File: rtl/tt_prescaler.sv
`timescale 1ns/1ps
module tt_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_new,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] pcnt;
        logic [PSC_W-1:0] psc_act;
    } pre_t;

    pre_t s_d, s_q;

    assign tick = en && (s_q.pcnt == s_q.psc_act);

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.psc_act = psc_new;
        end
        if (restart) begin
            s_d.pcnt = '0;
        end else if (en) begin
            s_d.pcnt = tick ? '0 : s_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tt_counter.sv
`timescale 1ns/1ps
module tt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             down,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] lim_new,
    output logic             wrap,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] lim_act
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } ctr_t;

    ctr_t s_d, s_q;

    logic at_end;
    assign at_end = down ? (s_q.cnt == '0) : (s_q.cnt == s_q.lim);
    assign wrap   = tick && at_end;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.lim = lim_new;
        end
        if (restart) begin
            s_d.cnt = down ? lim_new : '0;
        end else if (tick) begin
            if (down) s_d.cnt = at_end ? lim_new : s_q.cnt - 1'b1;
            else      s_d.cnt = at_end ? '0      : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.lim <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign count   = s_q.cnt;
    assign lim_act = s_q.lim;
endmodule

// File: rtl/tt_flags.sv
`timescale 1ns/1ps
module tt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic uev,
    input  logic ie,
    input  logic clr,
    output logic pulse,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic pulse;
        logic flag;
    } flg_t;

    flg_t s_d, s_q;

    always_comb begin
        s_d.pulse = uev;
        s_d.flag  = (uev && ie) || (s_q.flag && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse = s_q.pulse;
    assign flag  = s_q.flag;
    assign irq   = s_q.flag && ie;
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PSC_W  = 16,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [tt_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [CNT_W-1:0]          count,
    output logic                      upd_pulse,
    output logic                      upd_flag,
    output logic                      irq
);
    import tt_pkg::*;

    ctrl_t             ctrl;
    logic [PSC_W-1:0]  psc_hold;
    logic [CNT_W-1:0]  lim_hold;
    logic [CNT_W-1:0]  lim_act;
    logic              force_req, clr_req, force_go;
    logic              tick, wrap, uev;
    logic              run_en, int_en, down_mode;

    assign run_en    = ctrl.en;
    assign int_en    = ctrl.ie;
    assign down_mode = ctrl.down;
    assign force_go  = force_req && run_en;
    assign uev       = wrap || force_go;

    tt_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctrl      (ctrl),
        .psc_hold  (psc_hold),
        .lim_hold  (lim_hold),
        .force_req (force_req),
        .clr_req   (clr_req)
    );

    tt_prescaler #(.PSC_W(PSC_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (run_en),
        .restart (force_go),
        .load    (uev),
        .psc_new (psc_hold),
        .tick    (tick)
    );

    tt_counter #(.CNT_W(CNT_W)) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .down    (down_mode),
        .restart (force_go),
        .load    (uev),
        .lim_new (lim_hold),
        .wrap    (wrap),
        .count   (count),
        .lim_act (lim_act)
    );

    tt_flags i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .uev   (uev),
        .ie    (int_en),
        .clr   (clr_req),
        .pulse (upd_pulse),
        .flag  (upd_flag),
        .irq   (irq)
    );
endmodule

// File: rtl/tt_timer_chk.sv
`timescale 1ns/1ps
module tt_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ie,
    input logic             clr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] lim_act,
    input logic             upd_pulse,
    input logic             upd_flag
);
    // R10
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    // R10
    no_event_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !upd_pulse);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !clr) |=> upd_flag);

    // R9
    flag_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> !$rose(upd_flag));

    // R5
    limit_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lim_act) |-> upd_pulse);

    // R4
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= lim_act);
endmodule

bind tick_timer tt_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (run_en),
    .ie        (int_en),
    .clr       (clr_req),
    .count     (count),
    .lim_act   (lim_act),
    .upd_pulse (upd_pulse),
    .upd_flag  (upd_flag)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        upd_pulse, upd_flag, irq;

    tick_timer i_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .count     (count),
        .upd_pulse (upd_pulse),
        .upd_flag  (upd_flag),
        .irq       (irq)
    );

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected update cycles
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                int missed;
                missed = exp_q.pop_front();
                chk(1'b0, "R7 missed update", cyc, missed);
            end
            if (upd_pulse) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected update", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(e == cyc, "R7 update timing", cyc, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push_train(input int first, input int period, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(first + k * period);
    endtask

    task automatic mon_start();
        exp_q.delete();
        mon_on = 1'b1;
    endtask

    task automatic mon_stop();
        chk(exp_q.size() == 0, "R7 pending updates", exp_q.size(), 0);
        mon_on = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        int c0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(count == 0, "R1 count", count, 0);
        chk(upd_pulse == 0 && upd_flag == 0 && irq == 0, "R1 outputs",
            {upd_pulse, upd_flag, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R6: up count, prescale 0, limit 4, period 5
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h5);
        mon_start();
        n = cyc;
        push_train(n + 1, 5, 4);
        wr(2'd3, 16'h1);
        chk(count == 0, "R6 count after force", count, 0);
        wait_to(n + 3);
        chk(count == 2, "R2 up step", count, 2);
        wait_to(n + 18);
        chk(upd_flag == 1, "R8 flag set", upd_flag, 1);
        chk(irq == 1, "R9 irq on", irq, 1);
        mon_stop();

        // R3 / R5: prescale 2, limit 3, then limit 1 written mid-period
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd3);
        mon_start();
        n = cyc;
        exp_q.push_back(n + 1);
        exp_q.push_back(n + 13);
        push_train(n + 19, 6, 2);
        wr(2'd3, 16'h1);
        wait_to(n + 3);
        chk(count == 0, "R3 hold during prescale", count, 0);
        wr(2'd2, 16'd1);
        chk(count == 1, "R3 prescaled step", count, 1);
        wait_to(n + 12);
        chk(count == 3, "R5 old limit kept", count, 3);
        wait_to(n + 17);
        chk(count == 1, "R5 new limit used", count, 1);
        wait_to(n + 27);
        mon_stop();

        // R4: down count, prescale 2, limit 1
        wr(2'd0, 16'h7);
        mon_start();
        n = cyc;
        push_train(n + 1, 6, 3);
        wr(2'd3, 16'h1);
        chk(count == 1, "R4 force loads limit", count, 1);
        wait_to(n + 4);
        chk(count == 0, "R4 down step", count, 0);
        wait_to(n + 7);
        chk(count == 1, "R4 reload on wrap", count, 1);
        wait_to(n + 15);
        mon_stop();

        // R8 / R9: long period, flag handling
        wr(2'd1, 16'd100);
        wr(2'd2, 16'd100);
        wr(2'd3, 16'h1);
        wr(2'd3, 16'h2);
        chk(upd_flag == 0, "R8 clear", upd_flag, 0);
        chk(irq == 0, "R9 irq off after clear", irq, 0);
        wr(2'd3, 16'h3);
        chk(upd_flag == 1, "R8 set beats clear", upd_flag, 1);
        chk(irq == 1, "R9 irq follows flag", irq, 1);
        wr(2'd3, 16'h2);
        wr(2'd0, 16'h3);
        wr(2'd3, 16'h1);
        chk(upd_flag == 0, "R9 no flag without ie", upd_flag, 0);
        wr(2'd0, 16'h7);
        wr(2'd3, 16'h1);
        wr(2'd0, 16'h3);
        chk(upd_flag == 1 && irq == 0, "R9 irq masked", {upd_flag, irq}, 2);

        // R10: disabled
        wr(2'd0, 16'h2);
        c0 = count;
        mon_start();
        repeat (20) @(negedge clk);
        chk(count == c0, "R10 count holds", count, c0);
        wr(2'd3, 16'h1);
        repeat (5) @(negedge clk);
        chk(count == c0, "R10 force ignored", count, c0);
        mon_stop();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule